// File: doc/BRIEF.md
# Break and Sync Baud-Rate Measurement Unit

This block sits beside a UART receiver and measures the sender's bit rate from a header placed ahead of each frame. The header has three parts. First comes a long stretch of low line, the break. A high stretch, the delimiter, follows it. Last comes a sync character carrying 0x55. The block times the falling edges of the sync character with a free-running cycle counter. From the measured span it derives an integer baud prescaler and a 3-bit fractional modulation value, and holds them on its outputs for the baud generator.

Software supplies a nominal bit time in clock cycles, which sets every threshold, and a required delimiter length in nominal bit times. A single-cycle strobe reports each outcome: a new setting, a malformed sync character, or a break that ran too long. Detection runs only while the auto-baud enable is high. The line is sampled once per clock and goes through two registers before any decision.

Top module: `autobaud_detect`

## Requirements
- R1: During and right after reset, prescalerO and modulationO are 0 and doneO, syncErrO and brkTimeoutO are low.
- R2: A low run of L sampled cycles counts as a break only if L >= 11*nomBitI. A shorter low run is discarded, and the block waits for the next falling edge.
- R3: When a low run reaches 22*nomBitI samples, brkTimeoutO pulses for one cycle. The header is then abandoned until the line is seen high again. A run of 22*nomBitI-1 samples that then rises is still accepted as a break.
- R4: After a break, the high run before the next falling edge must be at least delimBitsI*nomBitI samples. Otherwise that falling edge starts a new break measurement.
- R5: The falling edge that ends a valid delimiter is sync edge 0. Four further falling edges are timestamped. The span is the cycle distance from edge 0 to edge 4, and it is the sum of the four edge intervals.
- R6: With overSampleI=1, the result is computed from t=span+8. modulationO = t[6:4] and prescalerO = t>>7, which is span/128 rounded to eighths.
- R7: With overSampleI=0, prescalerO = span>>3 and modulationO = span[2:0].
- R8: If any interval iv satisfies |32*iv - 8*span| > span, meaning it is more than a quarter bit away from the mean, syncErrO pulses and prescalerO and modulationO keep their previous values.
- R9: While collecting sync edges, if 4*nomBitI cycles pass after an edge without a further falling edge, syncErrO pulses and the header is abandoned.
- R10: While enableI is low, no header is tracked, no strobe is raised, and the settings keep their values.
- R11: The strobes last one cycle and never coincide. The settings change only in the cycle that doneO is high, and they carry the new values in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enableI | input | 1 | Auto-baud detection enable |
| overSampleI | input | 1 | 1: prescaler for a 16x oversampled generator; 0: prescaler per bit |
| rxIn | input | 1 | Receive line, idle high |
| nomBitI | input | NOM_W | Nominal bit time in clock cycles |
| delimBitsI | input | DLM_W | Minimum delimiter length in nominal bit times |
| prescalerO | output | CNT_W-1 | Measured integer prescaler |
| modulationO | output | 3 | Measured fractional modulation |
| doneO | output | 1 | One-cycle strobe: new setting loaded |
| syncErrO | output | 1 | One-cycle strobe: malformed or stalled sync character |
| brkTimeoutO | output | 1 | One-cycle strobe: break exceeded its limit |

## Verification
The hardest cases to reach from the ports are the exact thresholds. These are a break of 11*nomBitI and of 22*nomBitI-1 samples, a delimiter exactly at its minimum, and a sync character whose bit lengths differ so that the span has a non-zero fraction. The stimulus shapes every header from a table of per-bit cycle counts, driven at the falling clock edge, so each run length lands on a chosen sample count. A behavioural model then follows the same sampled line and predicts every strobe and setting cycle by cycle.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_DELIM,
    ST_SYNC,
    ST_CHECK,
    ST_DRAIN
  } abdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntLoad;
    logic cntInc;
    logic syncStart;
    logic edgeTake;
    logic commit;
    logic reportErr;
    logic reportTo;
  } abdCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lineLow;
    logic fallEdge;
    logic brkLongEnough;
    logic brkTooLong;
    logic delimMet;
    logic gapExpired;
    logic lastEdge;
    logic syncShapeOk;
  } abdStat_t;

endpackage

// File: rtl/abd_ctrl.sv
module abd_ctrl
  import abd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enableI,
  input  abdStat_t stat,
  output abdCtrl_t ctrl
);

  abdState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    if (!enableI) begin
      stateD = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (stat.fallEdge) begin
            ctrl.cntLoad = 1'b1;
            stateD       = ST_BREAK;
          end
        end
        ST_BREAK: begin
          if (stat.lineLow) begin
            if (stat.brkTooLong) begin
              ctrl.reportTo = 1'b1;
              stateD        = ST_DRAIN;
            end else begin
              ctrl.cntInc = 1'b1;
            end
          end else if (stat.brkLongEnough) begin
            ctrl.cntLoad = 1'b1;
            stateD       = ST_DELIM;
          end else begin
            stateD = ST_IDLE;
          end
        end
        ST_DELIM: begin
          if (stat.lineLow) begin
            if (stat.delimMet) begin
              ctrl.syncStart = 1'b1;
              stateD         = ST_SYNC;
            end else begin
              ctrl.cntLoad = 1'b1;
              stateD       = ST_BREAK;
            end
          end else begin
            ctrl.cntInc = 1'b1;
          end
        end
        ST_SYNC: begin
          if (stat.fallEdge) begin
            ctrl.edgeTake = 1'b1;
            if (stat.lastEdge) stateD = ST_CHECK;
          end else if (stat.gapExpired) begin
            ctrl.reportErr = 1'b1;
            stateD         = ST_DRAIN;
          end
        end
        ST_CHECK: begin
          if (stat.syncShapeOk) ctrl.commit    = 1'b1;
          else                  ctrl.reportErr = 1'b1;
          stateD = ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!stat.lineLow) stateD = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/abd_dpath.sv
module abd_dpath
  import abd_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int NOM_W = 12,
  parameter int DLM_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              overSampleI,
  input  logic              rxIn,
  input  logic [NOM_W-1:0]  nomBitI,
  input  logic [DLM_W-1:0]  delimBitsI,
  input  abdCtrl_t          ctrl,
  output abdStat_t          stat,
  output logic [CNT_W-2:0]  prescalerO,
  output logic [2:0]        modulationO,
  output logic              doneO,
  output logic              syncErrO,
  output logic              brkTimeoutO
);

  localparam int SPAN_W  = CNT_W + 2;
  localparam int PRE_W   = CNT_W - 1;
  localparam int EXT_W   = SPAN_W + 6;
  localparam int N_IV    = 4;
  localparam int OSPRE_W = SPAN_W - 6;
  localparam logic [CNT_W-1:0] K11 = CNT_W'(11);
  localparam logic [CNT_W-1:0] K22 = CNT_W'(22);

  // line sampling
  logic rxS, prevS;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxS   <= 1'b1;
      prevS <= 1'b1;
    end else begin
      rxS   <= rxIn;
      prevS <= rxS;
    end
  end

  // thresholds from the nominal bit time
  logic [CNT_W-1:0] nomW, brkMin, brkMax, gapMax, delimNeed;
  assign nomW      = {{(CNT_W-NOM_W){1'b0}}, nomBitI};
  assign brkMin    = nomW * K11;
  assign brkMax    = nomW * K22;
  assign gapMax    = nomW << 2;
  assign delimNeed = nomW * {{(CNT_W-DLM_W){1'b0}}, delimBitsI};

  // run-length counter
  logic [CNT_W-1:0] cntQ;
  always_ff @(posedge clk) begin
    if (!rstN)                          cntQ <= '0;
    else if (ctrl.cntLoad)              cntQ <= CNT_W'(1);
    else if (ctrl.cntInc && cntQ != '1) cntQ <= cntQ + 1'b1;
  end

  // free-running timebase and edge intervals
  logic [CNT_W-1:0] freeQ, lastTsQ, sinceEdge;
  logic [1:0]       edgeIdxQ;
  logic [CNT_W-1:0] ivQ [N_IV];

  assign sinceEdge = freeQ - lastTsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeQ    <= '0;
      lastTsQ  <= '0;
      edgeIdxQ <= '0;
      for (int i = 0; i < N_IV; i++) ivQ[i] <= '0;
    end else begin
      freeQ <= freeQ + 1'b1;
      if (ctrl.syncStart) begin
        lastTsQ  <= freeQ;
        edgeIdxQ <= '0;
      end else if (ctrl.edgeTake) begin
        ivQ[edgeIdxQ] <= sinceEdge;
        lastTsQ       <= freeQ;
        edgeIdxQ      <= edgeIdxQ + 1'b1;
      end
    end
  end

  // span and per-interval shape check
  logic [SPAN_W-1:0] span;
  always_comb begin
    span = '0;
    for (int i = 0; i < N_IV; i++) span = span + SPAN_W'(ivQ[i]);
  end

  logic [N_IV-1:0] ivOk;
  for (genvar g = 0; g < N_IV; g++) begin : g_shape
    logic [EXT_W-1:0] scaledIv, scaledSpan, dev;
    assign scaledIv   = EXT_W'(ivQ[g]) << 5;
    assign scaledSpan = EXT_W'(span) << 3;
    assign dev        = (scaledIv > scaledSpan) ? scaledIv - scaledSpan
                                                : scaledSpan - scaledIv;
    assign ivOk[g]    = dev <= EXT_W'(span);
  end

  // prescaler and modulation candidates
  logic [SPAN_W:0]    rounded;
  logic [PRE_W-1:0]   preNew;
  logic [2:0]         modNew;
  logic [OSPRE_W-1:0] preOs;
  assign rounded = {1'b0, span} + (SPAN_W+1)'(8);
  assign preOs   = rounded[SPAN_W:7];

  always_comb begin
    if (overSampleI) begin
      preNew = PRE_W'(preOs);
      modNew = rounded[6:4];
    end else begin
      preNew = span[SPAN_W-1:3];
      modNew = span[2:0];
    end
  end

  // status to control
  always_comb begin
    stat.lineLow       = ~rxS;
    stat.fallEdge      = prevS & ~rxS;
    stat.brkLongEnough = cntQ >= brkMin;
    stat.brkTooLong    = (cntQ + 1'b1) >= brkMax;
    stat.delimMet      = cntQ >= delimNeed;
    stat.gapExpired    = sinceEdge >= gapMax;
    stat.lastEdge      = edgeIdxQ == 2'd3;
    stat.syncShapeOk   = &ivOk;
  end

  // outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescalerO  <= '0;
      modulationO <= '0;
      doneO       <= 1'b0;
      syncErrO    <= 1'b0;
      brkTimeoutO <= 1'b0;
    end else begin
      doneO       <= ctrl.commit;
      syncErrO    <= ctrl.reportErr;
      brkTimeoutO <= ctrl.reportTo;
      if (ctrl.commit) begin
        prescalerO  <= preNew;
        modulationO <= modNew;
      end
    end
  end

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import abd_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int NOM_W = 12,
  parameter int DLM_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableI,
  input  logic              overSampleI,
  input  logic              rxIn,
  input  logic [NOM_W-1:0]  nomBitI,
  input  logic [DLM_W-1:0]  delimBitsI,
  output logic [CNT_W-2:0]  prescalerO,
  output logic [2:0]        modulationO,
  output logic              doneO,
  output logic              syncErrO,
  output logic              brkTimeoutO
);

  abdCtrl_t ctrlW;
  abdStat_t statW;

  abd_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .enableI (enableI),
    .stat    (statW),
    .ctrl    (ctrlW)
  );

  abd_dpath #(
    .CNT_W (CNT_W),
    .NOM_W (NOM_W),
    .DLM_W (DLM_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .overSampleI (overSampleI),
    .rxIn        (rxIn),
    .nomBitI     (nomBitI),
    .delimBitsI  (delimBitsI),
    .ctrl        (ctrlW),
    .stat        (statW),
    .prescalerO  (prescalerO),
    .modulationO (modulationO),
    .doneO       (doneO),
    .syncErrO    (syncErrO),
    .brkTimeoutO (brkTimeoutO)
  );

endmodule

// File: rtl/autobaud_detect_chk.sv
module autobaud_detect_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             enableI,
  input logic             rxIn,
  input logic [CNT_W-2:0] prescalerO,
  input logic [2:0]       modulationO,
  input logic             doneO,
  input logic             syncErrO,
  input logic             brkTimeoutO
);

  // R11: strobes never coincide
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneO, syncErrO, brkTimeoutO}));

  // R10: no strobe follows a cycle with detection disabled
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enableI) |-> !doneO && !syncErrO && !brkTimeoutO);

  // R8 / R11: settings move only together with doneO
  p_hold_settings_r8: assert property (@(posedge clk) disable iff (!rstN)
    !doneO |-> $stable(prescalerO) && $stable(modulationO));

  // R3: a timeout is only reported after a low line sample
  p_timeout_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    brkTimeoutO |-> !$past(rxIn, 2));

endmodule

bind autobaud_detect autobaud_detect_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .enableI     (enableI),
  .rxIn        (rxIn),
  .prescalerO  (prescalerO),
  .modulationO (modulationO),
  .doneO       (doneO),
  .syncErrO    (syncErrO),
  .brkTimeoutO (brkTimeoutO)
);

// File: tb/autobaud_detect_tb_top.sv
`timescale 1ns/1ps
module autobaud_detect_tb_top;

  localparam int CNT_W = 20;
  localparam int NOM_W = 12;
  localparam int DLM_W = 3;
  localparam int NOM   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableI = 1'b1;
  logic overSampleI = 1'b1;
  logic rxIn = 1'b1;
  logic [NOM_W-1:0] nomBitI = NOM_W'(NOM);
  logic [DLM_W-1:0] delimBitsI = DLM_W'(2);
  logic [CNT_W-2:0] prescalerO;
  logic [2:0] modulationO;
  logic doneO, syncErrO, brkTimeoutO;

  always #2.5 clk = ~clk;

  autobaud_detect #(.CNT_W(CNT_W), .NOM_W(NOM_W), .DLM_W(DLM_W)) dut_i (
    .clk(clk), .rstN(rstN), .enableI(enableI), .overSampleI(overSampleI),
    .rxIn(rxIn), .nomBitI(nomBitI), .delimBitsI(delimBitsI),
    .prescalerO(prescalerO), .modulationO(modulationO), .doneO(doneO),
    .syncErrO(syncErrO), .brkTimeoutO(brkTimeoutO));

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int doneSeen = 0, errSeen = 0, toSeen = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mState = 0, run = 0, cyc = 0;
  int edges[$];
  bit mR = 1, mP = 1, mLate = 1;
  int eDone = 0, eErr = 0, eTo = 0, ePre = 0, eMod = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; run = 0; cyc = 0; mR = 1; mP = 1; mLate = 1;
      eDone = 0; eErr = 0; eTo = 0; ePre = 0; eMod = 0;
      edges.delete();
    end else begin
      int nom, dl;
      nom = int'(nomBitI);
      dl  = int'(delimBitsI);
      cyc++;
      mP = mR; mR = mLate;
      eDone = 0; eErr = 0; eTo = 0;
      if (!enableI) mState = 0;
      else begin
        case (mState)
          0: if (mP && !mR) begin run = 1; mState = 1; end
          1: if (!mR) begin
               if (run + 1 >= 22*nom) begin eTo = 1; mState = 5; end
               else run++;
             end else if (run >= 11*nom) begin run = 1; mState = 2; end
             else mState = 0;
          2: if (!mR) begin
               if (run >= dl*nom) begin edges.delete(); edges.push_back(cyc); mState = 3; end
               else begin run = 1; mState = 1; end
             end else run++;
          3: if (mP && !mR) begin
               edges.push_back(cyc);
               if (edges.size() == 5) mState = 4;
             end else if (cyc - edges[$] >= 4*nom) begin eErr = 1; mState = 5; end
          4: begin
               int span, d;
               bit ok;
               span = edges[4] - edges[0];
               ok = 1;
               for (int i = 0; i < 4; i++) begin
                 d = 32*(edges[i+1]-edges[i]) - 8*span;
                 if (d < 0) d = -d;
                 if (d > span) ok = 0;
               end
               if (!ok) eErr = 1;
               else begin
                 eDone = 1;
                 if (overSampleI) begin ePre = (span + 8) / 128; eMod = ((span + 8) / 16) % 8; end
                 else begin ePre = span / 8; eMod = span % 8; end
               end
               mState = 5;
             end
          5: if (mR) mState = 0;
          default: mState = 0;
        endcase
      end
      mLate = rxIn;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R5 done", int'(doneO), eDone);
      chk("R8 syncErr", int'(syncErrO), eErr);
      chk("R3 brkTimeout", int'(brkTimeoutO), eTo);
      chk("R6 prescaler", int'(prescalerO), ePre);
      chk("R7 modulation", int'(modulationO), eMod);
      if (doneO) doneSeen++;
      if (syncErrO) errSeen++;
      if (brkTimeoutO) toSeen++;
    end
  end

  // ---------------- stimulus ----------------
  int bitLen[9];

  task automatic level(bit v, int n);
    rxIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic setAll(int p);
    for (int i = 0; i < 9; i++) bitLen[i] = p;
  endtask

  // break, delimiter, then 0x55 with per-bit lengths, stop and idle
  task automatic header(int brk, int dlm);
    level(1'b0, brk);
    level(1'b1, dlm);
    level(1'b0, bitLen[0]);
    for (int i = 0; i < 8; i++) level(((8'h55 >> i) & 1) != 0, bitLen[i+1]);
    level(1'b1, 300);
  endtask

  task automatic snap(output int d, output int e, output int t);
    d = doneSeen; e = errSeen; t = toSeen;
  endtask

  initial begin
    int d0, e0, t0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 prescaler", int'(prescalerO), 0);
    chk("R1 strobes", int'({doneO, syncErrO, brkTimeoutO}), 0);
    rstN = 1'b1;
    level(1'b1, 50);
    chk("R1 after reset", int'({prescalerO, modulationO}), 0);

    // R2 R5 R6: oversampled, all bits 37 -> span 296
    overSampleI = 1'b1; setAll(37);
    snap(d0, e0, t0); header(500, 100);
    chk("R5 one done", doneSeen - d0, 1);
    chk("R6 prescaler", int'(prescalerO), 2);
    chk("R6 modulation", int'(modulationO), 3);

    // R7: per-bit mode, alternating 37/38 -> span 300
    overSampleI = 1'b0;
    for (int i = 0; i < 9; i++) bitLen[i] = (i % 2 == 0) ? 37 : 38;
    snap(d0, e0, t0); header(600, 90);
    chk("R7 one done", doneSeen - d0, 1);
    chk("R7 prescaler", int'(prescalerO), 37);
    chk("R7 modulation", int'(modulationO), 4);

    // R8: skewed first interval -> error, settings held
    setAll(30); bitLen[0] = 40; bitLen[1] = 40;
    snap(d0, e0, t0); header(500, 100);
    chk("R8 error", errSeen - e0, 1);
    chk("R8 no done", doneSeen - d0, 0);
    chk("R8 prescaler held", int'(prescalerO), 37);
    chk("R8 modulation held", int'(modulationO), 4);

    // R9: start bit then line stays high
    snap(d0, e0, t0);
    level(1'b0, 500); level(1'b1, 100); level(1'b0, 37); level(1'b1, 400);
    chk("R9 gap error", errSeen - e0, 1);
    chk("R9 prescaler held", int'(prescalerO), 37);

    // R3: timeout at 22*NOM, then 22*NOM-1 accepted as a break
    snap(d0, e0, t0);
    level(1'b0, 22*NOM); level(1'b1, 200);
    chk("R3 timeout", toSeen - t0, 1);
    chk("R3 no done", doneSeen - d0, 0);
    setAll(40);
    snap(d0, e0, t0); header(22*NOM-1, 100);
    chk("R3 no timeout below limit", toSeen - t0, 0);
    chk("R3 done below limit", doneSeen - d0, 1);
    chk("R7 prescaler 40", int'(prescalerO), 40);

    // R2: break one sample short
    setAll(37);
    snap(d0, e0, t0); header(11*NOM-1, 100);
    chk("R2 short break ignored", doneSeen - d0 + errSeen - e0, 0);
    chk("R2 prescaler held", int'(prescalerO), 40);

    // R4: delimiter one short, then exactly at limit with minimum break
    snap(d0, e0, t0); header(500, 2*NOM-1);
    chk("R4 short delimiter", doneSeen - d0, 0);
    overSampleI = 1'b1; setAll(41);
    snap(d0, e0, t0); header(11*NOM, 2*NOM);
    chk("R4 exact delimiter done", doneSeen - d0, 1);
    chk("R6 prescaler 41", int'(prescalerO), 2);
    chk("R6 modulation 41", int'(modulationO), 5);

    // R10: disabled detection
    enableI = 1'b0; setAll(37);
    snap(d0, e0, t0); header(500, 100);
    chk("R10 no strobes", doneSeen - d0 + errSeen - e0 + toSeen - t0, 0);
    chk("R10 prescaler held", int'(prescalerO), 2);
    enableI = 1'b1;
    level(1'b1, 20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule